// File: doc/BRIEF.md
# Variable-Length Instruction Format Decoder

This block looks at the first bytes of an instruction fetch window and works out which encoding class the instruction belongs to. The class follows from the leading opcode byte alone. From the class the block derives the instruction length in bytes. It also pulls out the register nibbles, the sub-opcode field and the 16-bit immediate, and raises flags for no-operation, halt, service-call and illegal encodings. The window is big-endian: byte 0 (the lowest address) sits in the most significant byte of the input bus.

A second, independent path helps compare-and-skip instructions. A taken skip must step over the whole following instruction, and the length of that instruction depends on its own first byte. The helper takes that byte and returns the number of bytes to skip.

Both paths are registered. When the window is marked valid, every result appears on the outputs one clock later. When it is not marked valid, the outputs keep their last values.

Top module: `insn_shape_decoder`

## Requirements
- R1: The length output is 6 when the opcode byte is 0xE0 or 0xE1, and 4 for every other opcode.
- R2: The class code is 0 for opcode 0x00, 1 for 0x01, 2 for 0x05, 3 for 0x09, 4 for 0x0D, 5 for 0x3C, 6 for 0x42, 7 for 0xB0..0xB5, 8 for 0xE0, 9 for 0xE1 and 10 for 0xFF. Every other opcode gets class 11 (illegal); this includes 0xB6..0xBF and 0x3D..0x41.
- R3: Class 1 uses byte 1 as the sub-opcode, byte 2 as the fields ra (high nibble) and rb (low nibble), and byte 3 as the fields rc (high nibble) and rd (low nibble).
- R4: Class 2 uses byte 1 and the high nibble of byte 2 as a 12-bit sub-opcode. The fields are ra = low nibble of byte 2, rb = high nibble of byte 3 and rc = low nibble of byte 3.
- R5: Class 3 uses bytes 1..2 as a 16-bit sub-opcode, with ra and rb taken from the high and low nibbles of byte 3. Class 4 uses bytes 1..2 and the high nibble of byte 3 as a 20-bit sub-opcode, with ra taken from the low nibble of byte 3.
- R6: Class 9 decodes its sub-opcode and registers the same way as class 3. Class 8 decodes them the same way as class 4. In both classes bytes 4..5 form the immediate, with byte 4 as the high byte.
- R7: Class 5 uses byte 1 as the sub-opcode and bytes 2..3 as the immediate. Class 6 puts bytes 1..3 on the 24-bit sub-opcode output as a service code, with byte 1 as the most significant byte.
- R8: Class 7 puts the whole opcode byte on the sub-opcode output. Its fields are ra = high nibble of byte 1, rb = low nibble of byte 1, and an immediate made from bytes 2..3.
- R9: The no-op flag is set only for opcode 0x00. Opcode 0xFF always sets the halt flag. The service flag is set only for class 6.
- R10: The illegal flag is set only for class 11. If the trap-enable input is 0, an illegal opcode also sets the halt flag. If trap-enable is 1, an illegal opcode does not set it.
- R11: The immediate appears both sign-extended and zero-extended to the register width, and the has-immediate flag is set only for classes 5, 7, 8 and 9. Any sub-opcode bits, register fields or immediate bits that the class does not define read as 0.
- R12: The skip helper returns 6 when the next-instruction byte is 0xE0 or 0xE1, and 4 for any other value.
- R13: Every result appears one clock after a cycle in which the input is valid, and the output-valid flag is set for that one cycle. In a cycle where the input is not valid, the decoded outputs keep their values and output-valid goes to 0. After reset, every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld_i | input | 1 | Window is valid and is captured this cycle |
| win_i | input | 8*WIN_BYTES | Fetch window, byte 0 in the most significant byte |
| trap_en_i | input | 1 | A handler exists for illegal opcodes |
| next_op_i | input | 8 | First byte of the instruction that follows |
| out_vld_o | output | 1 | Results are fresh this cycle |
| fmt_o | output | 4 | Class code |
| len_o | output | 3 | Instruction length in bytes |
| sub_o | output | 24 | Sub-opcode or service code, right-aligned |
| ra_o | output | 4 | Register field a |
| rb_o | output | 4 | Register field b |
| rc_o | output | 4 | Register field c |
| rd_o | output | 4 | Register field d |
| imm_sx_o | output | XLEN | Immediate, sign-extended |
| imm_zx_o | output | XLEN | Immediate, zero-extended |
| has_imm_o | output | 1 | The class carries an immediate |
| nop_o | output | 1 | No-operation |
| halt_o | output | 1 | Halt |
| svc_o | output | 1 | Service call |
| illegal_o | output | 1 | Undefined opcode |
| skip_len_o | output | 3 | Bytes to skip past the next instruction |

## Verification
The assertions check on every cycle that the lengths are only 4 or 6 and that both wide classes report 6. They also check that the no-op, service and illegal flags never overlap, that a no-op never halts, that the two immediate forms agree in their low 16 bits, and that the outputs hold whenever the input is idle. Some behaviour depends on exact values and only the bench scenarios can show it: which byte and nibble feeds each field in each class, where the class boundaries fall at 0xB5/0xB6 and 0xE0/0xE1, and how the trap-enable input decides whether an illegal opcode halts.

// File: rtl/insn_fmt_pkg.sv
package insn_fmt_pkg;

  localparam int SUB_W = 24;
  localparam int NIB_W = 4;
  localparam int IMM_W = 16;
  localparam int LEN_W = 3;

  typedef enum logic [3:0] {
    FMT_NOP  = 4'd0,
    FMT_R4   = 4'd1,
    FMT_R3   = 4'd2,
    FMT_R2   = 4'd3,
    FMT_R1   = 4'd4,
    FMT_JREL = 4'd5,
    FMT_SVC  = 4'd6,
    FMT_BITI = 4'd7,
    FMT_I1   = 4'd8,
    FMT_I2   = 4'd9,
    FMT_HALT = 4'd10,
    FMT_BAD  = 4'd11
  } fmt_e;

  typedef struct packed {
    fmt_e             fmt;
    logic [LEN_W-1:0] len;
    logic             nop;
    logic             halt;
    logic             svc;
    logic             illegal;
  } cls_t;

  typedef struct packed {
    logic [SUB_W-1:0] sub;
    logic [NIB_W-1:0] ra;
    logic [NIB_W-1:0] rb;
    logic [NIB_W-1:0] rc;
    logic [NIB_W-1:0] rd;
    logic [IMM_W-1:0] imm;
    logic             has_imm;
  } fld_t;

endpackage

// File: rtl/insn_opclass.sv
module insn_opclass
  import insn_fmt_pkg::*;
(
  input  logic [7:0] op_i,
  input  logic       trap_en_i,
  output cls_t       cls_o
);

  fmt_e fmt;

  always_comb begin
    case (op_i) inside
      8'h00:          fmt = FMT_NOP;
      8'h01:          fmt = FMT_R4;
      8'h05:          fmt = FMT_R3;
      8'h09:          fmt = FMT_R2;
      8'h0D:          fmt = FMT_R1;
      8'h3C:          fmt = FMT_JREL;
      8'h42:          fmt = FMT_SVC;
      [8'hB0:8'hB5]:  fmt = FMT_BITI;
      8'hE0:          fmt = FMT_I1;
      8'hE1:          fmt = FMT_I2;
      8'hFF:          fmt = FMT_HALT;
      default:        fmt = FMT_BAD;
    endcase
  end

  always_comb begin
    cls_o.fmt     = fmt;
    cls_o.len     = ((fmt == FMT_I1) || (fmt == FMT_I2)) ? LEN_W'(6) : LEN_W'(4);
    cls_o.nop     = (fmt == FMT_NOP);
    cls_o.svc     = (fmt == FMT_SVC);
    cls_o.illegal = (fmt == FMT_BAD);
    cls_o.halt    = (fmt == FMT_HALT) || ((fmt == FMT_BAD) && !trap_en_i);
  end

endmodule

// File: rtl/insn_field_split.sv
module insn_field_split
  import insn_fmt_pkg::*;
#(
  parameter int WIN_BYTES = 6
) (
  input  logic [WIN_BYTES*8-1:0] win_i,
  input  fmt_e                   fmt_i,
  output fld_t                   fld_o
);

  logic [7:0] b [WIN_BYTES];

  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_byte
    assign b[k] = win_i[(WIN_BYTES-1-k)*8 +: 8];
  end

  always_comb begin
    fld_o = '0;
    case (fmt_i)
      FMT_R4: begin
        fld_o.sub = SUB_W'(b[1]);
        fld_o.ra  = b[2][7:4];
        fld_o.rb  = b[2][3:0];
        fld_o.rc  = b[3][7:4];
        fld_o.rd  = b[3][3:0];
      end
      FMT_R3: begin
        fld_o.sub = SUB_W'({b[1], b[2][7:4]});
        fld_o.ra  = b[2][3:0];
        fld_o.rb  = b[3][7:4];
        fld_o.rc  = b[3][3:0];
      end
      FMT_R2: begin
        fld_o.sub = SUB_W'({b[1], b[2]});
        fld_o.ra  = b[3][7:4];
        fld_o.rb  = b[3][3:0];
      end
      FMT_R1: begin
        fld_o.sub = SUB_W'({b[1], b[2], b[3][7:4]});
        fld_o.ra  = b[3][3:0];
      end
      FMT_JREL: begin
        fld_o.sub     = SUB_W'(b[1]);
        fld_o.imm     = {b[2], b[3]};
        fld_o.has_imm = 1'b1;
      end
      FMT_SVC: begin
        fld_o.sub = {b[1], b[2], b[3]};
      end
      FMT_BITI: begin
        fld_o.sub     = SUB_W'(b[0]);
        fld_o.ra      = b[1][7:4];
        fld_o.rb      = b[1][3:0];
        fld_o.imm     = {b[2], b[3]};
        fld_o.has_imm = 1'b1;
      end
      FMT_I2: begin
        fld_o.sub     = SUB_W'({b[1], b[2]});
        fld_o.ra      = b[3][7:4];
        fld_o.rb      = b[3][3:0];
        fld_o.imm     = {b[4], b[5]};
        fld_o.has_imm = 1'b1;
      end
      FMT_I1: begin
        fld_o.sub     = SUB_W'({b[1], b[2], b[3][7:4]});
        fld_o.ra      = b[3][3:0];
        fld_o.imm     = {b[4], b[5]};
        fld_o.has_imm = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/insn_skip_len.sv
module insn_skip_len
  import insn_fmt_pkg::*;
(
  input  logic [7:0]       next_op_i,
  output logic [LEN_W-1:0] skip_o
);

  always_comb begin
    if ((next_op_i == 8'hE0) || (next_op_i == 8'hE1)) skip_o = LEN_W'(6);
    else                                             skip_o = LEN_W'(4);
  end

endmodule

// File: rtl/insn_shape_decoder.sv
module insn_shape_decoder
  import insn_fmt_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int WIN_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_vld_i,
  input  logic [WIN_BYTES*8-1:0] win_i,
  input  logic                   trap_en_i,
  input  logic [7:0]             next_op_i,
  output logic                   out_vld_o,
  output logic [3:0]             fmt_o,
  output logic [LEN_W-1:0]       len_o,
  output logic [SUB_W-1:0]       sub_o,
  output logic [NIB_W-1:0]       ra_o,
  output logic [NIB_W-1:0]       rb_o,
  output logic [NIB_W-1:0]       rc_o,
  output logic [NIB_W-1:0]       rd_o,
  output logic [XLEN-1:0]        imm_sx_o,
  output logic [XLEN-1:0]        imm_zx_o,
  output logic                   has_imm_o,
  output logic                   nop_o,
  output logic                   halt_o,
  output logic                   svc_o,
  output logic                   illegal_o,
  output logic [LEN_W-1:0]       skip_len_o
);

  localparam int WIN_W = WIN_BYTES * 8;
  localparam int EXT_W = XLEN - IMM_W;

  cls_t             cls_d;
  fld_t             fld_d;
  logic [LEN_W-1:0] skip_d;
  logic [XLEN-1:0]  imm_sx_d;
  logic [XLEN-1:0]  imm_zx_d;

  cls_t             cls_q;
  fld_t             fld_q;
  logic [LEN_W-1:0] skip_q;
  logic [XLEN-1:0]  imm_sx_q;
  logic [XLEN-1:0]  imm_zx_q;
  logic             vld_q;

  insn_opclass u_opclass (
    .op_i      (win_i[WIN_W-1 -: 8]),
    .trap_en_i (trap_en_i),
    .cls_o     (cls_d)
  );

  insn_field_split #(.WIN_BYTES(WIN_BYTES)) u_fields (
    .win_i (win_i),
    .fmt_i (cls_d.fmt),
    .fld_o (fld_d)
  );

  insn_skip_len u_skip (
    .next_op_i (next_op_i),
    .skip_o    (skip_d)
  );

  always_comb begin
    imm_sx_d = {{EXT_W{fld_d.imm[IMM_W-1]}}, fld_d.imm};
    imm_zx_d = {{EXT_W{1'b0}}, fld_d.imm};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      cls_q    <= '0;
      fld_q    <= '0;
      skip_q   <= '0;
      imm_sx_q <= '0;
      imm_zx_q <= '0;
    end else begin
      vld_q <= in_vld_i;
      if (in_vld_i) begin
        cls_q    <= cls_d;
        fld_q    <= fld_d;
        skip_q   <= skip_d;
        imm_sx_q <= imm_sx_d;
        imm_zx_q <= imm_zx_d;
      end
    end
  end

  assign out_vld_o  = vld_q;
  assign fmt_o      = cls_q.fmt;
  assign len_o      = cls_q.len;
  assign nop_o      = cls_q.nop;
  assign halt_o     = cls_q.halt;
  assign svc_o      = cls_q.svc;
  assign illegal_o  = cls_q.illegal;
  assign sub_o      = fld_q.sub;
  assign ra_o       = fld_q.ra;
  assign rb_o       = fld_q.rb;
  assign rc_o       = fld_q.rc;
  assign rd_o       = fld_q.rd;
  assign has_imm_o  = fld_q.has_imm;
  assign imm_sx_o   = imm_sx_q;
  assign imm_zx_o   = imm_zx_q;
  assign skip_len_o = skip_q;

  assert_len_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld_o |-> (len_o == LEN_W'(4) || len_o == LEN_W'(6)));

  assert_wide_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_o && (fmt_o == 4'd8 || fmt_o == 4'd9)) |-> (len_o == LEN_W'(6)));

  assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld_o |-> $onehot0({nop_o, svc_o, illegal_o}));

  assert_nop_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nop_o |-> !halt_o);

  assert_imm_agree_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld_o |-> (imm_sx_o[IMM_W-1:0] == imm_zx_o[IMM_W-1:0]));

  assert_skip_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld_o |-> (skip_len_o == LEN_W'(4) || skip_len_o == LEN_W'(6)));

  assert_vld_follow_R13: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld_i |=> out_vld_o);

  assert_hold_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld_i |=> (!out_vld_o && $stable(sub_o) && $stable(fmt_o) && $stable(imm_zx_o)));

endmodule

// File: tb/test_insn_shape_decoder.sv
module test_insn_shape_decoder;

  localparam int XLEN = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld_i;
  logic [47:0] win_i;
  logic        trap_en_i;
  logic [7:0]  next_op_i;
  logic        out_vld_o;
  logic [3:0]  fmt_o;
  logic [2:0]  len_o;
  logic [23:0] sub_o;
  logic [3:0]  ra_o, rb_o, rc_o, rd_o;
  logic [XLEN-1:0] imm_sx_o, imm_zx_o;
  logic        has_imm_o, nop_o, halt_o, svc_o, illegal_o;
  logic [2:0]  skip_len_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  insn_shape_decoder #(.XLEN(XLEN), .WIN_BYTES(6)) i_insn_shape_decoder (
    .clk(clk), .rst_n(rst_n), .in_vld_i(in_vld_i), .win_i(win_i),
    .trap_en_i(trap_en_i), .next_op_i(next_op_i), .out_vld_o(out_vld_o),
    .fmt_o(fmt_o), .len_o(len_o), .sub_o(sub_o), .ra_o(ra_o), .rb_o(rb_o),
    .rc_o(rc_o), .rd_o(rd_o), .imm_sx_o(imm_sx_o), .imm_zx_o(imm_zx_o),
    .has_imm_o(has_imm_o), .nop_o(nop_o), .halt_o(halt_o), .svc_o(svc_o),
    .illegal_o(illegal_o), .skip_len_o(skip_len_o)
  );

  // expected values
  logic [3:0]  e_fmt;
  logic [2:0]  e_len;
  logic [23:0] e_sub;
  logic [3:0]  e_ra, e_rb, e_rc, e_rd;
  logic [15:0] e_imm;
  logic        e_has, e_nop, e_halt, e_svc, e_ill;
  logic [2:0]  e_skip;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (win %012h)", req, act, exp, win_i);
    end
  endtask

  task automatic model(input logic [47:0] w, input logic trap, input logic [7:0] nx);
    logic [7:0] b0, b1, b2, b3, b4, b5;
    {b0, b1, b2, b3, b4, b5} = w;
    e_sub = '0; e_ra = '0; e_rb = '0; e_rc = '0; e_rd = '0; e_imm = '0; e_has = 1'b0;
    if (b0 == 8'h00) e_fmt = 4'd0;
    else if (b0 == 8'h01) e_fmt = 4'd1;
    else if (b0 == 8'h05) e_fmt = 4'd2;
    else if (b0 == 8'h09) e_fmt = 4'd3;
    else if (b0 == 8'h0D) e_fmt = 4'd4;
    else if (b0 == 8'h3C) e_fmt = 4'd5;
    else if (b0 == 8'h42) e_fmt = 4'd6;
    else if (b0 >= 8'hB0 && b0 <= 8'hB5) e_fmt = 4'd7;
    else if (b0 == 8'hE0) e_fmt = 4'd8;
    else if (b0 == 8'hE1) e_fmt = 4'd9;
    else if (b0 == 8'hFF) e_fmt = 4'd10;
    else e_fmt = 4'd11;
    e_len = (b0 == 8'hE0 || b0 == 8'hE1) ? 3'd6 : 3'd4;
    case (e_fmt)
      4'd1: begin e_sub = {16'd0, b1}; e_ra = b2[7:4]; e_rb = b2[3:0]; e_rc = b3[7:4]; e_rd = b3[3:0]; end
      4'd2: begin e_sub = {12'd0, b1, b2[7:4]}; e_ra = b2[3:0]; e_rb = b3[7:4]; e_rc = b3[3:0]; end
      4'd3: begin e_sub = {8'd0, b1, b2}; e_ra = b3[7:4]; e_rb = b3[3:0]; end
      4'd4: begin e_sub = {4'd0, b1, b2, b3[7:4]}; e_ra = b3[3:0]; end
      4'd5: begin e_sub = {16'd0, b1}; e_imm = {b2, b3}; e_has = 1'b1; end
      4'd6: e_sub = {b1, b2, b3};
      4'd7: begin e_sub = {16'd0, b0}; e_ra = b1[7:4]; e_rb = b1[3:0]; e_imm = {b2, b3}; e_has = 1'b1; end
      4'd8: begin e_sub = {4'd0, b1, b2, b3[7:4]}; e_ra = b3[3:0]; e_imm = {b4, b5}; e_has = 1'b1; end
      4'd9: begin e_sub = {8'd0, b1, b2}; e_ra = b3[7:4]; e_rb = b3[3:0]; e_imm = {b4, b5}; e_has = 1'b1; end
      default: ;
    endcase
    e_nop  = (e_fmt == 4'd0);
    e_svc  = (e_fmt == 4'd6);
    e_ill  = (e_fmt == 4'd11);
    e_halt = (e_fmt == 4'd10) || (e_ill && !trap);
    e_skip = (nx == 8'hE0 || nx == 8'hE1) ? 3'd6 : 3'd4;
  endtask

  task automatic check_all();
    check("R13 out_vld", 64'(out_vld_o), 64'd1);
    check("R2 class", 64'(fmt_o), 64'(e_fmt));
    check("R1 length", 64'(len_o), 64'(e_len));
    check("R3 R4 R5 R6 R7 R8 sub", 64'(sub_o), 64'(e_sub));
    check("R3 R4 R5 R6 R8 ra", 64'(ra_o), 64'(e_ra));
    check("R3 R4 R5 R6 R8 rb", 64'(rb_o), 64'(e_rb));
    check("R3 R4 rc", 64'(rc_o), 64'(e_rc));
    check("R3 rd", 64'(rd_o), 64'(e_rd));
    check("R11 imm_sx", 64'(imm_sx_o), 64'({{16{e_imm[15]}}, e_imm}));
    check("R11 imm_zx", 64'(imm_zx_o), 64'({16'd0, e_imm}));
    check("R11 has_imm", 64'(has_imm_o), 64'(e_has));
    check("R9 nop", 64'(nop_o), 64'(e_nop));
    check("R9 R10 halt", 64'(halt_o), 64'(e_halt));
    check("R9 svc", 64'(svc_o), 64'(e_svc));
    check("R10 illegal", 64'(illegal_o), 64'(e_ill));
    check("R12 skip", 64'(skip_len_o), 64'(e_skip));
  endtask

  task automatic send(input logic [47:0] w, input logic trap, input logic [7:0] nx);
    @(negedge clk);
    in_vld_i = 1'b1; win_i = w; trap_en_i = trap; next_op_i = nx;
    model(w, trap, nx);
    @(negedge clk);
    in_vld_i = 1'b0;
    check_all();
  endtask

  function automatic logic [7:0] pick_op(input int unsigned r, input logic [7:0] rnd);
    case (r % 20)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h05;  3: return 8'h09;
      4: return 8'h0D;  5: return 8'h3C;  6: return 8'h42;  7: return 8'hB0;
      8: return 8'hB5;  9: return 8'hB6;  10: return 8'hE0; 11: return 8'hE1;
      12: return 8'hFF; 13: return 8'h3D; 14: return 8'hBF; 15: return 8'hDF;
      default: return rnd;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_vld_i = 1'b0; win_i = '0; trap_en_i = 1'b0; next_op_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 reset out_vld", 64'(out_vld_o), 64'd0);
    check("R13 reset fmt", 64'(fmt_o), 64'd0);
    check("R13 reset len", 64'(len_o), 64'd0);
    check("R13 reset halt", 64'(halt_o), 64'd0);
    check("R13 reset sub", 64'(sub_o), 64'd0);

    // directed cases
    send(48'h01_5A_12_34_99_99, 1'b0, 8'h00);     // R3
    send(48'h05_AB_CD_EF_00_00, 1'b0, 8'hE0);     // R4, R12 wide next
    send(48'h09_12_34_56_00_00, 1'b0, 8'hE1);     // R5
    send(48'h0D_12_34_56_00_00, 1'b0, 8'hDF);     // R5
    send(48'hE1_00_0E_3C_80_01, 1'b0, 8'h05);     // R6 negative imm
    send(48'hE0_00_2D_17_7F_FE, 1'b0, 8'hFF);     // R6
    send(48'h3C_00_FF_F0_00_00, 1'b0, 8'h3C);     // R7
    send(48'h42_10_02_00_00_00, 1'b0, 8'h42);     // R7 service
    send(48'hB5_4C_80_00_00_00, 1'b0, 8'hB0);     // R8 edge
    send(48'hB6_4C_80_00_00_00, 1'b1, 8'hB0);     // R8 first illegal, trapped
    send(48'h00_12_34_56_78_9A, 1'b0, 8'h00);     // R9 nop
    send(48'hFF_FF_FF_FF_FF_FF, 1'b1, 8'h00);     // R9 halt with trap
    send(48'h3D_00_00_00_00_00, 1'b0, 8'h01);     // R10 no handler
    send(48'h43_00_00_00_00_00, 1'b1, 8'h01);     // R10 handler present

    // R13 hold while idle
    @(negedge clk);
    win_i = 48'h01_FF_FF_FF_00_00; trap_en_i = 1'b0; next_op_i = 8'hE0;
    @(negedge clk);
    check("R13 idle out_vld", 64'(out_vld_o), 64'd0);
    check("R13 idle hold fmt", 64'(fmt_o), 64'(e_fmt));
    check("R13 idle hold sub", 64'(sub_o), 64'(e_sub));
    check("R13 idle hold skip", 64'(skip_len_o), 64'(e_skip));

    // random
    for (int i = 0; i < 600; i++) begin
      logic [47:0] w;
      logic [7:0]  nx;
      w = {$urandom, $urandom};
      w[47:40] = pick_op($urandom, 8'($urandom));
      nx = pick_op($urandom, 8'($urandom));
      send(w, 1'($urandom), nx);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule